// File: doc/BRIEF.md
# TDM multichannel serial sequencer

This block sequences time-division multichannel operation for a serial port pair whose transmit and receive halves share one serial clock. One enable input starts multichannel activity on both halves. After a fixed start-up delay, the block emits an internal frame sync. It then walks through the programmed number of channel slots. For each slot it drives slot-valid strobes to the transmit and receive shift paths and reports the index of the channel being serviced.

The channel count is programmed as the number of channels minus one, so a 7-bit field covers 1 to 128 channels. Every slot lasts a fixed, parameterised number of serial clocks. The frame sync is a single-clock pulse in the clock just before slot 0. Multichannel mode must not be combined with either standard port enable. If software sets them together, the block flags a configuration error and does not start.

Top module: `tdm_mc_seq`

## Requirements
- R1: Reset (rst_n low) drives mc_active, fsync, tx_slot, rx_slot, slot_end, cfg_err low and chan_idx to 0.
- R2: With mc_en high and both standard enables low, mc_active goes high after the third rising sclk edge that samples this legal enable. It stays low after the first and second edges.
- R3: The first frame sync pulse appears one clock after mc_active rises, which is after the fourth edge. It lasts exactly one clock, and tx_slot and rx_slot are low in that clock.
- R4: tx_slot and rx_slot are high in every clock from the fifth edge onward while the enable stays legal. Neither is ever high while mc_active is low.
- R5: Each slot lasts SLOT_BITS clocks (default 8). slot_end is high only in the last clock of each slot.
- R6: chan_idx starts at 0 in the first slot and rises by one at every slot boundary. After the slot whose index equals ch_last it wraps to 0, so ch_last = channels - 1 and 0 gives one channel, 127 gives 128.
- R7: After the first pulse, fsync is high exactly in the last clock of the slot whose index equals ch_last. The frame therefore repeats every (ch_last+1)*SLOT_BITS clocks.
- R8: One edge that samples mc_en low returns mc_active, fsync, tx_slot, rx_slot, slot_end to low and chan_idx to 0. The start-up delay then restarts from zero.
- R9: An edge that samples mc_en high together with std_tx_en or std_rx_en sets cfg_err and keeps or returns all activity outputs low. cfg_err clears one edge after the conflict ends, and a legal enable then starts the R2 delay afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_en | input | 1 | Multichannel enable for both transmit and receive halves |
| std_tx_en | input | 1 | Standard (non-multichannel) transmit enable |
| std_rx_en | input | 1 | Standard (non-multichannel) receive enable |
| ch_last | input | CH_W (7) | Number of channels minus one |
| mc_active | output | 1 | Multichannel activity has started |
| fsync | output | 1 | Internal frame sync, one-clock pulse before slot 0 |
| chan_idx | output | CH_W (7) | Channel currently serviced |
| slot_end | output | 1 | Last clock of the current slot |
| tx_slot | output | 1 | Transmit slot-valid strobe |
| rx_slot | output | 1 | Receive slot-valid strobe |
| cfg_err | output | 1 | Multichannel enable set together with a standard enable |

## Verification
The single-pulse fsync property and the channel step and wrap properties take for granted that ch_last stays put while the sequencer runs. The bench changes ch_last only while mc_en is low. The properties accept any mix of enable inputs, so the bench drives legal starts, conflicting enables on each standard input and aborts in mid-frame. Every input changes on the falling edge, away from the sampling edge.

// File: rtl/tdm_mc_pkg.sv
`timescale 1ns/1ps
package tdm_mc_pkg;
   // Start-up phases of the sequencer
   typedef enum logic [1:0] {
      PH_WAIT = 2'd0,   // counting the start-up delay
      PH_ARM  = 2'd1,   // active, frame sync not yet issued
      PH_LEAD = 2'd2,   // first frame sync clock
      PH_RUN  = 2'd3    // slots running
   } mc_phase_e;
endpackage

// File: rtl/tdm_mc_enable_ctl.sv
`timescale 1ns/1ps
module tdm_mc_enable_ctl
   import tdm_mc_pkg::*;
#(
   parameter int EN_LAT = 3
) (
   input  logic      sclk,
   input  logic      rst_n,
   input  logic      mc_en,
   input  logic      std_tx_en,
   input  logic      std_rx_en,
   output logic      keep,
   output mc_phase_e phase,
   output logic      cfg_err
);
   localparam int LAT_W = (EN_LAT < 2) ? 1 : $clog2(EN_LAT);
   localparam logic [LAT_W-1:0] LAT_TOP = LAT_W'(EN_LAT - 1);

   initial begin
      assert (EN_LAT >= 1) else $error("EN_LAT must be at least 1");
   end

   logic             conflict;
   logic [LAT_W-1:0] lat_q;
   mc_phase_e        phase_q;
   logic             err_q;

   assign conflict = mc_en & (std_tx_en | std_rx_en);
   assign keep     = mc_en & ~conflict;

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q   <= '0;
         phase_q <= PH_WAIT;
         err_q   <= 1'b0;
      end else begin
         err_q <= conflict;
         if (!keep) begin
            lat_q   <= '0;
            phase_q <= PH_WAIT;
         end else begin
            unique case (phase_q)
               PH_WAIT: begin
                  if (lat_q == LAT_TOP) phase_q <= PH_ARM;
                  else                  lat_q   <= lat_q + 1'b1;
               end
               PH_ARM:  phase_q <= PH_LEAD;
               PH_LEAD: phase_q <= PH_RUN;
               PH_RUN:  phase_q <= PH_RUN;
               default: phase_q <= PH_WAIT;
            endcase
         end
      end
   end

   assign phase   = phase_q;
   assign cfg_err = err_q;

   // R9: a conflicting enable is flagged and never lets the sequencer run
   a_r9_conflict_blocks: assert property (@(posedge sclk) disable iff (!rst_n)
      conflict |=> (err_q && phase_q == PH_WAIT));

   // R2: leaving the wait phase needs a legal enable on the edge before
   a_r2_start_needs_keep: assert property (@(posedge sclk) disable iff (!rst_n)
      (phase_q == PH_WAIT) ##1 (phase_q == PH_ARM) |-> $past(keep));
endmodule

// File: rtl/tdm_mc_slot_ctr.sv
`timescale 1ns/1ps
module tdm_mc_slot_ctr #(
   parameter int CH_W      = 7,
   parameter int SLOT_BITS = 8
) (
   input  logic            sclk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            keep,
   input  logic [CH_W-1:0] ch_last,
   output logic [CH_W-1:0] ch_idx,
   output logic            slot_last
);
   initial begin
      assert (SLOT_BITS >= 1) else $error("SLOT_BITS must be at least 1");
      assert (CH_W >= 1 && CH_W <= 8) else $error("CH_W out of range");
   end

   logic [CH_W-1:0] ch_q;
   logic            wrap;

   assign wrap = (ch_q >= ch_last);

   generate
      if (SLOT_BITS == 1) begin : g_single
         // each clock is a whole slot: no bit counter
         assign slot_last = 1'b1;
      end else begin : g_multi
         localparam int BIT_W = $clog2(SLOT_BITS);
         localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(SLOT_BITS - 1);
         logic [BIT_W-1:0] bit_q;
         always_ff @(posedge sclk or negedge rst_n) begin
            if (!rst_n)              bit_q <= '0;
            else if (!keep || !run)  bit_q <= '0;
            else if (bit_q == BIT_TOP) bit_q <= '0;
            else                     bit_q <= bit_q + 1'b1;
         end
         assign slot_last = (bit_q == BIT_TOP);
      end
   endgenerate

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)                ch_q <= '0;
      else if (!keep || !run)    ch_q <= '0;
      else if (slot_last)        ch_q <= wrap ? '0 : ch_q + 1'b1;
   end

   assign ch_idx = ch_q;

   // R6: wrap to channel zero after the last programmed channel
   a_r6_chan_wrap: assert property (@(posedge sclk) disable iff (!rst_n)
      (run && slot_last && ch_q >= ch_last) |=> (ch_q == '0));

   // R6: step by one at a slot boundary below the limit
   a_r6_chan_step: assert property (@(posedge sclk) disable iff (!rst_n)
      (run && keep && slot_last && ch_q < ch_last) |=> (ch_q == $past(ch_q) + 1'b1));

   // R6: index holds inside a slot
   a_r6_chan_hold: assert property (@(posedge sclk) disable iff (!rst_n)
      (run && keep && !slot_last) |=> $stable(ch_q));
endmodule

// File: rtl/tdm_mc_seq.sv
`timescale 1ns/1ps
module tdm_mc_seq
   import tdm_mc_pkg::*;
#(
   parameter int CH_W      = 7,
   parameter int SLOT_BITS = 8,
   parameter int EN_LAT    = 3
) (
   input  logic            sclk,
   input  logic            rst_n,
   input  logic            mc_en,
   input  logic            std_tx_en,
   input  logic            std_rx_en,
   input  logic [CH_W-1:0] ch_last,
   output logic            mc_active,
   output logic            fsync,
   output logic [CH_W-1:0] chan_idx,
   output logic            slot_end,
   output logic            tx_slot,
   output logic            rx_slot,
   output logic            cfg_err
);
   localparam bit ONE_CLK_FRAME_OK = (SLOT_BITS == 1);

   logic      keep;
   mc_phase_e phase;
   logic      run;
   logic      slot_last;
   logic [CH_W-1:0] ch_idx;

   tdm_mc_enable_ctl #(.EN_LAT(EN_LAT)) u_en (
      .sclk      (sclk),
      .rst_n     (rst_n),
      .mc_en     (mc_en),
      .std_tx_en (std_tx_en),
      .std_rx_en (std_rx_en),
      .keep      (keep),
      .phase     (phase),
      .cfg_err   (cfg_err)
   );

   assign run = (phase == PH_RUN);

   tdm_mc_slot_ctr #(.CH_W(CH_W), .SLOT_BITS(SLOT_BITS)) u_slot (
      .sclk      (sclk),
      .rst_n     (rst_n),
      .run       (run),
      .keep      (keep),
      .ch_last   (ch_last),
      .ch_idx    (ch_idx),
      .slot_last (slot_last)
   );

   assign mc_active = (phase != PH_WAIT);
   assign fsync     = (phase == PH_LEAD) | (run & slot_last & (ch_idx >= ch_last));
   assign tx_slot   = run;
   assign rx_slot   = run;
   assign slot_end  = run & slot_last;
   assign chan_idx  = ch_idx;

   // R8: one low enable sample clears all activity
   a_r8_disable_clears: assert property (@(posedge sclk) disable iff (!rst_n)
      !mc_en |=> (!mc_active && !fsync && !tx_slot && !rx_slot && chan_idx == '0));

   // R4: strobes only after the activation delay
   a_r4_strobe_needs_active: assert property (@(posedge sclk) disable iff (!rst_n)
      (tx_slot || rx_slot) |-> mc_active);

   // R3: first frame sync follows activation by one clock
   a_r3_first_fsync: assert property (@(posedge sclk) disable iff (!rst_n)
      ($rose(mc_active) && keep) |=> (fsync && !tx_slot));

   // R3/R7: frame sync is a single-clock pulse when a frame is longer than one clock
   a_r7_fsync_single: assert property (@(posedge sclk) disable iff (!rst_n)
      (fsync && $stable(ch_last) && (ch_last != '0 || !ONE_CLK_FRAME_OK)) |=> !fsync);
endmodule

// File: tb/tb_tdm_mc_seq.sv
`timescale 1ns/1ps
module tb_tdm_mc_seq;
   localparam int W  = 8;
   localparam int NC = 4;
   localparam logic [6:0] CFG_LAST [NC] = '{7'd0, 7'd1, 7'd3, 7'd127};
   localparam int         CFG_CYC  [NC] = '{40, 60, 100, 1050};

   logic sclk = 1'b0;
   logic rst_n = 1'b0;
   logic mc_en = 1'b0, std_tx_en = 1'b0, std_rx_en = 1'b0;
   logic [6:0] ch_last = '0;
   logic mc_active, fsync, slot_end, tx_slot, rx_slot, cfg_err;
   logic [6:0] chan_idx;

   int checks = 0;
   int errors = 0;

   always #2.5 sclk = ~sclk;

   tdm_mc_seq dut (
      .sclk(sclk), .rst_n(rst_n), .mc_en(mc_en), .std_tx_en(std_tx_en),
      .std_rx_en(std_rx_en), .ch_last(ch_last), .mc_active(mc_active),
      .fsync(fsync), .chan_idx(chan_idx), .slot_end(slot_end),
      .tx_slot(tx_slot), .rx_slot(rx_slot), .cfg_err(cfg_err)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge sclk);
      @(negedge sclk);
   endtask

   task automatic chk_idle(string req);
      chk(req, "mc_active", int'(mc_active), 0);
      chk(req, "fsync", int'(fsync), 0);
      chk(req, "tx_slot", int'(tx_slot), 0);
      chk(req, "rx_slot", int'(rx_slot), 0);
      chk(req, "slot_end", int'(slot_end), 0);
      chk(req, "chan_idx", int'(chan_idx), 0);
   endtask

   // compare one clock against the reference schedule; c = edges since legal enable
   task automatic chk_cycle(int c, int n);
      int t, b, ch, e_fs, e_run;
      e_run = (c >= 5) ? 1 : 0;
      t  = c - 5;
      b  = (c >= 5) ? t % W : 0;
      ch = (c >= 5) ? (t / W) % n : 0;
      e_fs = (c == 4 || (c >= 5 && b == W-1 && ch == n-1)) ? 1 : 0;
      chk("R2", $sformatf("mc_active c=%0d", c), int'(mc_active), (c >= 3) ? 1 : 0);
      chk((c <= 5) ? "R3" : "R7", $sformatf("fsync c=%0d", c), int'(fsync), e_fs);
      chk("R4", $sformatf("tx_slot c=%0d", c), int'(tx_slot), e_run);
      chk("R4", $sformatf("rx_slot c=%0d", c), int'(rx_slot), e_run);
      chk("R5", $sformatf("slot_end c=%0d", c), int'(slot_end), (e_run == 1 && b == W-1) ? 1 : 0);
      chk("R6", $sformatf("chan_idx c=%0d", c), int'(chan_idx), ch);
   endtask

   initial begin
      repeat (3) @(negedge sclk);
      // R1: reset state
      chk_idle("R1");
      chk("R1", "cfg_err", int'(cfg_err), 0);
      rst_n = 1'b1;
      step();

      // table walk over channel counts
      for (int k = 0; k < NC; k++) begin
         mc_en   = 1'b0;
         ch_last = CFG_LAST[k];
         step();
         step();
         mc_en = 1'b1;
         for (int c = 1; c <= CFG_CYC[k]; c++) begin
            step();
            chk_cycle(c, int'(CFG_LAST[k]) + 1);
         end
      end

      // R8: abort mid-frame, then restart delay from zero
      mc_en = 1'b0;
      step();
      chk_idle("R8");
      ch_last = 7'd2;
      mc_en = 1'b1;
      for (int c = 1; c <= 30; c++) begin
         step();
         chk_cycle(c, 3);
      end
      mc_en = 1'b0;
      step();
      chk_idle("R8");

      // R9: conflict with transmit standard enable
      mc_en = 1'b1;
      std_tx_en = 1'b1;
      for (int c = 1; c <= 6; c++) begin
         step();
         chk("R9", "cfg_err tx", int'(cfg_err), 1);
         chk_idle("R9");
      end
      std_tx_en = 1'b0;
      for (int c = 1; c <= 12; c++) begin
         step();
         if (c == 1) chk("R9", "cfg_err cleared", int'(cfg_err), 0);
         chk_cycle(c, 3);
      end
      // R9: conflict raised while running aborts it
      std_rx_en = 1'b1;
      step();
      chk("R9", "cfg_err rx", int'(cfg_err), 1);
      chk_idle("R9");
      std_rx_en = 1'b0;
      mc_en = 1'b0;
      step();
      chk("R9", "cfg_err off", int'(cfg_err), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge sclk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule